// File: doc/BRIEF.md
# Multi-Cycle Sequenced Processor Core

This block is a small, non-pipelined 16-bit processor. It executes each instruction as a fixed walk through separate steps. It reads the instruction word, advances the program counter, splits the word into held fields, fetches the operands from the register file, performs the operation, and writes the result back. There are sixteen general-purpose registers, each 16 bits wide. A status word carries zero, negative, carry and error flags. The core drives one word-addressed port to an instruction memory and one to a data memory. Both memories are synchronous, and read data returns one cycle after the address.

Every instruction is a 32-bit word. A register-form instruction uses only its upper 20 bits and leaves the lower 12 bits zero. A memory-form instruction fills the whole word with a 16-bit address operand. The core stops at a halt instruction or at an opcode it does not recognise, and it stays stopped until reset.

Top module: `cpu_core`

## Requirements
- R1: While reset is asserted, halted is 0, status is 0, imem_addr is 0 and dmem_we is 0. Execution starts at instruction address 0.
- R2: Instruction word fields are: opcode in bits [31:24], field A in [23:20], field B in [19:16], field C in [15:12], and the address operand in [15:0]. A register-form instruction writes register A with the result of B op C.
- R3: The Boolean opcodes are 0x01 (A = ~B), 0x02 (AND), 0x03 (OR) and 0x04 (XOR).
- R4: Opcode 0x05 adds B and C modulo 2^16. The carry out of bit 15 goes to the carry flag.
- R5: The shift opcodes are 0x10 logical left, 0x11 logical right, 0x12 arithmetic left and 0x13 arithmetic right. The shift amount is register C modulo 16. An arithmetic right shift refills with the sign bit.
- R6: Opcode 0x20 loads data word [address] into register A. Opcode 0x21 stores register A to data word [address], with dmem_we high for exactly one cycle.
- R7: Opcode 0x30 jumps to the address operand. Opcode 0x31 jumps there only when bit 0 of register A is 1; otherwise execution continues with the next word.
- R8: Opcode 0x00 halts the core. After a halt, halted stays 1, imem_addr stays constant and no data write happens until reset.
- R9: The status bits are [0] zero, [1] negative, [2] carry and [3] error. Every Boolean, add or shift instruction updates zero, negative and carry; carry is 0 for every operation except add. Loads, stores and branches leave the flags unchanged.
- R10: An undefined opcode sets the error flag and halts the core. Zero, negative and carry keep their values, and no later instruction runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 16 | Instruction memory word address (the program counter) |
| imem_rdata | input | 32 | Instruction word, one cycle after the address |
| dmem_addr | output | 16 | Data memory word address |
| dmem_wdata | output | 16 | Data to write |
| dmem_we | output | 1 | Write strobe, one cycle per store |
| dmem_rdata | input | 16 | Read data, one cycle after the address |
| halted | output | 1 | Core is stopped |
| status | output | 4 | Flags: error, carry, negative, zero (bit 3 to bit 0) |

## Verification
The bound checker watches rules that must hold on every cycle. A halt or error state persists and keeps the program counter frozen. Stores are single-cycle pulses that never occur while halted. The error flag is never set without the halt state.

The data results of each operation, shift behaviour at the sign bit and for amounts of 16 or more, the flag values, and which path a branch takes can only be shown by bench programs. The scoreboard compares every store the core issues with a value worked out by hand from the requirements.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 16;
    localparam int INSTR_W = 32;
    localparam int NREG    = 16;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int OPC_W   = 8;

    localparam logic [OPC_W-1:0] OPC_HALT = 8'h00;
    localparam logic [OPC_W-1:0] OPC_NOT  = 8'h01;
    localparam logic [OPC_W-1:0] OPC_AND  = 8'h02;
    localparam logic [OPC_W-1:0] OPC_OR   = 8'h03;
    localparam logic [OPC_W-1:0] OPC_XOR  = 8'h04;
    localparam logic [OPC_W-1:0] OPC_ADD  = 8'h05;
    localparam logic [OPC_W-1:0] OPC_SHL  = 8'h10;
    localparam logic [OPC_W-1:0] OPC_SHR  = 8'h11;
    localparam logic [OPC_W-1:0] OPC_ASL  = 8'h12;
    localparam logic [OPC_W-1:0] OPC_ASR  = 8'h13;
    localparam logic [OPC_W-1:0] OPC_LD   = 8'h20;
    localparam logic [OPC_W-1:0] OPC_ST   = 8'h21;
    localparam logic [OPC_W-1:0] OPC_JMP  = 8'h30;
    localparam logic [OPC_W-1:0] OPC_BRT  = 8'h31;

    // flag positions inside the status word
    localparam int FLG_Z = 0;
    localparam int FLG_N = 1;
    localparam int FLG_C = 2;
    localparam int FLG_E = 3;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_FWAIT  = 4'd1,
        ST_INCR   = 4'd2,
        ST_DECODE = 4'd3,
        ST_READ   = 4'd4,
        ST_EXEC   = 4'd5,
        ST_MWAIT  = 4'd6,
        ST_WB     = 4'd7,
        ST_HALT   = 4'd8
    } step_e;

    typedef struct packed {
        step_e               step;
        logic [ADDR_W-1:0]   pc;
        logic [INSTR_W-1:0]  ir;
        logic [OPC_W-1:0]    opc;
        logic [RIDX_W-1:0]   fa;
        logic [RIDX_W-1:0]   fb;
        logic [RIDX_W-1:0]   fc;
        logic [ADDR_W-1:0]   imm;
        logic [DATA_W-1:0]   opa;
        logic [DATA_W-1:0]   opb;
        logic [DATA_W-1:0]   res;
        logic [3:0]          flags;
    } ctl_s;

    function automatic logic is_xform(input logic [OPC_W-1:0] opc);
        return (opc inside {OPC_NOT, OPC_AND, OPC_OR, OPC_XOR, OPC_ADD,
                            OPC_SHL, OPC_SHR, OPC_ASL, OPC_ASR});
    endfunction

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  raddr_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata
);

    logic [DATA_W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int W = 16,
    localparam int SH_W = $clog2(W)
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     res,
    output logic             carry
);

    logic [SH_W-1:0] amt;
    logic [W:0]      sum;

    assign amt = b[SH_W-1:0];
    assign sum = {1'b0, a} + {1'b0, b};

    always_comb begin
        res   = '0;
        carry = 1'b0;
        case (opc)
            OPC_NOT: res = ~a;
            OPC_AND: res = a & b;
            OPC_OR:  res = a | b;
            OPC_XOR: res = a ^ b;
            OPC_ADD: begin
                res   = sum[W-1:0];
                carry = sum[W];
            end
            OPC_SHL, OPC_ASL: res = a << amt;
            OPC_SHR: res = a >> amt;
            OPC_ASR: res = $unsigned($signed(a) >>> amt);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0]  imem_rdata,
    output logic [ADDR_W-1:0]   dmem_addr,
    output logic [DATA_W-1:0]   dmem_wdata,
    output logic                dmem_we,
    input  logic [DATA_W-1:0]   dmem_rdata,
    output logic [RIDX_W-1:0]   rf_raddr_a,
    output logic [RIDX_W-1:0]   rf_raddr_b,
    input  logic [DATA_W-1:0]   rf_rdata_a,
    input  logic [DATA_W-1:0]   rf_rdata_b,
    output logic                rf_we,
    output logic [RIDX_W-1:0]   rf_waddr,
    output logic [DATA_W-1:0]   rf_wdata,
    output logic [OPC_W-1:0]    alu_opc,
    output logic [DATA_W-1:0]   alu_a,
    output logic [DATA_W-1:0]   alu_b,
    input  logic [DATA_W-1:0]   alu_res,
    input  logic                alu_carry,
    output logic                halted,
    output logic [3:0]          status
);

    ctl_s ctl_q, ctl_d;

    always_comb begin
        ctl_d   = ctl_q;
        dmem_we = 1'b0;
        rf_we   = 1'b0;
        case (ctl_q.step)
            ST_FETCH:  ctl_d.step = ST_FWAIT;
            ST_FWAIT: begin
                ctl_d.ir   = imem_rdata;
                ctl_d.step = ST_INCR;
            end
            ST_INCR: begin
                ctl_d.pc   = ctl_q.pc + 1'b1;
                ctl_d.step = ST_DECODE;
            end
            ST_DECODE: begin
                ctl_d.opc  = ctl_q.ir[31:24];
                ctl_d.fa   = ctl_q.ir[23:20];
                ctl_d.fb   = ctl_q.ir[19:16];
                ctl_d.fc   = ctl_q.ir[15:12];
                ctl_d.imm  = ctl_q.ir[15:0];
                ctl_d.step = ST_READ;
            end
            ST_READ: begin
                ctl_d.opa  = rf_rdata_a;
                ctl_d.opb  = rf_rdata_b;
                ctl_d.step = ST_EXEC;
            end
            ST_EXEC: begin
                ctl_d.step = ST_FETCH;
                if (is_xform(ctl_q.opc)) begin
                    ctl_d.res          = alu_res;
                    ctl_d.flags[FLG_Z] = (alu_res == '0);
                    ctl_d.flags[FLG_N] = alu_res[DATA_W-1];
                    ctl_d.flags[FLG_C] = alu_carry;
                    ctl_d.step         = ST_WB;
                end else begin
                    case (ctl_q.opc)
                        OPC_LD:   ctl_d.step = ST_MWAIT;
                        OPC_ST:   dmem_we = 1'b1;
                        OPC_JMP:  ctl_d.pc = ctl_q.imm;
                        OPC_BRT:  if (ctl_q.opa[0]) ctl_d.pc = ctl_q.imm;
                        OPC_HALT: ctl_d.step = ST_HALT;
                        default: begin
                            ctl_d.flags[FLG_E] = 1'b1;
                            ctl_d.step         = ST_HALT;
                        end
                    endcase
                end
            end
            ST_MWAIT: begin
                ctl_d.res  = dmem_rdata;
                ctl_d.step = ST_WB;
            end
            ST_WB: begin
                rf_we      = 1'b1;
                ctl_d.step = ST_FETCH;
            end
            default: ctl_d.step = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // stores and conditional branches read register A on port A
    assign rf_raddr_a = (ctl_q.opc == OPC_ST || ctl_q.opc == OPC_BRT) ? ctl_q.fa : ctl_q.fb;
    assign rf_raddr_b = ctl_q.fc;
    assign rf_waddr   = ctl_q.fa;
    assign rf_wdata   = ctl_q.res;
    assign alu_opc    = ctl_q.opc;
    assign alu_a      = ctl_q.opa;
    assign alu_b      = ctl_q.opb;
    assign imem_addr  = ctl_q.pc;
    assign dmem_addr  = ctl_q.imm;
    assign dmem_wdata = ctl_q.opa;
    assign halted     = (ctl_q.step == ST_HALT);
    assign status     = ctl_q.flags;

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0]  imem_rdata,
    output logic [ADDR_W-1:0]   dmem_addr,
    output logic [DATA_W-1:0]   dmem_wdata,
    output logic                dmem_we,
    input  logic [DATA_W-1:0]   dmem_rdata,
    output logic                halted,
    output logic [3:0]          status
);

    logic [RIDX_W-1:0] rf_raddr_a, rf_raddr_b, rf_waddr;
    logic [DATA_W-1:0] rf_rdata_a, rf_rdata_b, rf_wdata;
    logic              rf_we;
    logic [OPC_W-1:0]  alu_opc;
    logic [DATA_W-1:0] alu_a, alu_b, alu_res;
    logic              alu_carry;

    cpu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (rf_raddr_a),
        .raddr_b (rf_raddr_b),
        .rdata_a (rf_rdata_a),
        .rdata_b (rf_rdata_b),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata)
    );

    cpu_alu #(.W(DATA_W)) u_alu (
        .opc   (alu_opc),
        .a     (alu_a),
        .b     (alu_b),
        .res   (alu_res),
        .carry (alu_carry)
    );

    cpu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .rf_raddr_a (rf_raddr_a),
        .rf_raddr_b (rf_raddr_b),
        .rf_rdata_a (rf_rdata_a),
        .rf_rdata_b (rf_rdata_b),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .alu_opc    (alu_opc),
        .alu_a      (alu_a),
        .alu_b      (alu_b),
        .alu_res    (alu_res),
        .alu_carry  (alu_carry),
        .halted     (halted),
        .status     (status)
    );

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] imem_addr,
    input logic        dmem_we,
    input logic        halted,
    input logic [3:0]  status
);

    // R8: once stopped, the core stays stopped
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8: no fetch address movement while stopped
    assert_pc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(imem_addr));

    // R8: no data write while stopped
    assert_no_write_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_we);

    // R6: every store is a single-cycle strobe
    assert_store_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we);

    // R10: the error flag only ever appears together with the halt state
    assert_err_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |-> halted);

    // R10: the error flag is not cleared before reset
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |=> status[3]);

endmodule

bind cpu_core cpu_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .halted    (halted),
    .status    (status)
);

// File: tb/tb_cpu_core.sv
module tb_cpu_core;

    localparam logic [7:0] K_HALT = 8'h00, K_NOT = 8'h01, K_AND = 8'h02, K_OR = 8'h03,
                           K_XOR = 8'h04, K_ADD = 8'h05, K_SHL = 8'h10, K_SHR = 8'h11,
                           K_ASL = 8'h12, K_ASR = 8'h13, K_LD = 8'h20, K_ST = 8'h21,
                           K_JMP = 8'h30, K_BRT = 8'h31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
    logic [31:0] imem_rdata;
    logic        dmem_we, halted;
    logic [3:0]  status;

    logic [31:0] imem [256];
    logic [15:0] dmem [256];

    int n_chk = 0;
    int n_fail = 0;
    int wp = 0;

    logic [15:0] exp_addr [$];
    logic [15:0] exp_data [$];
    string       exp_tag  [$];

    always #4 clk = ~clk;

    cpu_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .halted     (halted),
        .status     (status)
    );

    // synchronous memories, one cycle read latency
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[7:0]];
        dmem_rdata <= dmem[dmem_addr[7:0]];
        if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: each store is compared with the next expected item
    always @(negedge clk) begin
        if (rst_n && dmem_we) begin
            if (exp_addr.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R8 unexpected store actual=%h:%h expected=none", dmem_addr, dmem_wdata);
            end else begin
                automatic string       t = exp_tag.pop_front();
                automatic logic [15:0] a = exp_addr.pop_front();
                automatic logic [15:0] d = exp_data.pop_front();
                chk({t, " store"}, {dmem_addr, dmem_wdata}, {a, d});
            end
        end
    end

    task automatic expect_store(input string tag, input logic [15:0] a, input logic [15:0] d);
        exp_tag.push_back(tag);
        exp_addr.push_back(a);
        exp_data.push_back(d);
    endtask

    function automatic logic [31:0] enc_r(input logic [7:0] op, input int a, input int b, input int c);
        return {op, 4'(a), 4'(b), 4'(c), 12'h000};
    endfunction

    function automatic logic [31:0] enc_m(input logic [7:0] op, input int a, input logic [15:0] addr);
        return {op, 4'(a), 4'h0, addr};
    endfunction

    task automatic emit(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 16'h0;
        end
        dmem[8'h10] = 16'h00F0;
        dmem[8'h11] = 16'h0F0F;
        dmem[8'h12] = 16'h8001;
        dmem[8'h13] = 16'h0003;
        dmem[8'h14] = 16'h0001;
        dmem[8'h15] = 16'hFFFF;
        dmem[8'h16] = 16'h0013;
        wp = 0;
    endtask

    task automatic reset_core();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 halted in reset", 32'(halted), 32'd0);
        chk("R1 status in reset", 32'(status), 32'd0);
        chk("R1 pc in reset", 32'(imem_addr), 32'd0);
        chk("R1 no write in reset", 32'(dmem_we), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic run_until_halt(input string tag);
        int n = 0;
        while (!halted && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " reaches halt"}, 32'(halted), 32'd1);
        chk({tag, " all stores seen"}, 32'(exp_addr.size()), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] held_pc;

        // ---------- program 1: data transforms, shifts, branches (R2-R8) ----------
        clear_mem();
        emit(enc_m(K_LD, 1, 16'h10));        // 0
        emit(enc_m(K_LD, 2, 16'h11));        // 1
        emit(enc_m(K_LD, 3, 16'h12));        // 2
        emit(enc_m(K_LD, 4, 16'h13));        // 3
        emit(enc_m(K_LD, 9, 16'h16));        // 4
        emit(enc_r(K_AND, 5, 1, 2));         // 5
        emit(enc_m(K_ST, 5, 16'h40));        // 6
        emit(enc_r(K_OR, 5, 1, 2));          // 7
        emit(enc_m(K_ST, 5, 16'h41));        // 8
        emit(enc_r(K_XOR, 5, 2, 3));         // 9
        emit(enc_m(K_ST, 5, 16'h42));        // 10
        emit(enc_r(K_NOT, 5, 1, 0));         // 11
        emit(enc_m(K_ST, 5, 16'h43));        // 12
        emit(enc_r(K_ADD, 5, 1, 2));         // 13
        emit(enc_m(K_ST, 5, 16'h44));        // 14
        emit(enc_r(K_SHL, 5, 3, 4));         // 15
        emit(enc_m(K_ST, 5, 16'h45));        // 16
        emit(enc_r(K_SHR, 5, 3, 4));         // 17
        emit(enc_m(K_ST, 5, 16'h46));        // 18
        emit(enc_r(K_ASR, 5, 3, 4));         // 19
        emit(enc_m(K_ST, 5, 16'h47));        // 20
        emit(enc_r(K_ASL, 5, 3, 4));         // 21
        emit(enc_m(K_ST, 5, 16'h48));        // 22
        emit(enc_r(K_SHR, 5, 3, 9));         // 23 amount 0x13 -> 3
        emit(enc_m(K_ST, 5, 16'h49));        // 24
        emit(enc_m(K_JMP, 0, 16'd28));       // 25
        emit(enc_m(K_ST, 1, 16'h50));        // 26 skipped
        emit({K_HALT, 24'h0});               // 27 skipped
        emit(enc_m(K_BRT, 4, 16'd31));       // 28 r4 bit0 = 1 -> taken
        emit(enc_m(K_ST, 1, 16'h51));        // 29 skipped
        emit({K_HALT, 24'h0});               // 30 skipped
        emit(enc_m(K_BRT, 1, 16'd34));       // 31 r1 bit0 = 0 -> not taken
        emit(enc_m(K_ST, 2, 16'h4A));        // 32
        emit({K_HALT, 24'h0});               // 33
        emit(enc_m(K_ST, 1, 16'h52));        // 34 never reached
        emit({K_HALT, 24'h0});               // 35

        expect_store("R3 AND",            16'h40, 16'h0000);
        expect_store("R3 OR",             16'h41, 16'h0FFF);
        expect_store("R3 XOR",            16'h42, 16'h8F0E);
        expect_store("R3 NOT",            16'h43, 16'hFF0F);
        expect_store("R4 ADD",            16'h44, 16'h0FFF);
        expect_store("R5 SHL",            16'h45, 16'h0008);
        expect_store("R5 SHR",            16'h46, 16'h1000);
        expect_store("R5 ASR sign",       16'h47, 16'hF000);
        expect_store("R5 ASL",            16'h48, 16'h0008);
        expect_store("R5 amount mod 16",  16'h49, 16'h1000);
        expect_store("R7 BRT not taken",  16'h4A, 16'h0F0F);

        reset_core();
        run_until_halt("R8 prog1");
        chk("R7 branch path ends after word 33", 32'(imem_addr), 32'd34);
        chk("R9 flags after logical shift", 32'(status), 32'h0);
        chk("R6 store landed in memory", 32'(dmem[8'h42]), 32'h8F0E);
        held_pc = imem_addr;
        repeat (40) @(negedge clk);
        chk("R8 still halted", 32'(halted), 32'd1);
        chk("R8 pc held", 32'(imem_addr), 32'(held_pc));

        // ---------- program 2: add carry/zero, flags untouched by load/store/jump (R4 R9) ----------
        clear_mem();
        emit(enc_m(K_LD, 6, 16'h15));        // 0
        emit(enc_m(K_LD, 7, 16'h14));        // 1
        emit(enc_r(K_ADD, 8, 6, 7));         // 2 FFFF+1 -> 0, carry
        emit(enc_m(K_LD, 1, 16'h10));        // 3
        emit(enc_m(K_ST, 8, 16'h60));        // 4
        emit(enc_m(K_JMP, 0, 16'd7));        // 5
        emit(enc_m(K_ST, 1, 16'h62));        // 6 skipped
        emit({K_HALT, 24'h0});               // 7
        expect_store("R4 ADD wrap", 16'h60, 16'h0000);

        reset_core();
        run_until_halt("R9 prog2");
        chk("R9 Z and C kept across load/store/jump", 32'(status), 32'h5);
        chk("R7 jump target", 32'(imem_addr), 32'd8);

        // ---------- program 3: undefined opcode (R10) ----------
        clear_mem();
        emit(enc_m(K_LD, 6, 16'h15));        // 0
        emit(enc_r(K_ADD, 5, 6, 6));         // 1 FFFE, carry, negative
        emit(32'h7E00_0000);                 // 2 undefined
        emit(enc_m(K_ST, 5, 16'h61));        // 3 must not run
        emit({K_HALT, 24'h0});               // 4

        reset_core();
        run_until_halt("R10 prog3");
        chk("R10 error set, N and C kept", 32'(status), 32'hE);
        chk("R10 stopped after undefined word", 32'(imem_addr), 32'd3);
        repeat (20) @(negedge clk);
        chk("R10 no later store", 32'(dmem[8'h61]), 32'h0);

        // reset clears the stopped state again
        reset_core();
        @(negedge clk);
        chk("R1 leaves halt after reset", 32'(halted), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule